// File: doc/BRIEF.md
# Asynchronous Parallel EPROM Read Controller

This block sits on the system clock and fetches single bytes from an asynchronous parallel EPROM. The EPROM has a 20-bit address bus, an 8-bit data bus and two active-low strobes: a chip select and an output gate. The host raises `req` with an address while `ready` is high. The controller latches the address, drives it onto the memory bus and pulls chip select low. It lowers the output gate only late enough that both the address-access window and the shorter gate-access window end on the same clock edge. On that edge it samples the data bus, returns the byte with a one-cycle `rvalid` pulse and lifts both strobes together.

After the strobes rise, the EPROM needs time before its outputs stop driving the shared data bus. The controller counts that float time and does not accept a new request until the count is done. While `deselect` is high, no request is taken and chip select stays high, so the device remains in its low-power standby state.

The three timings are given as parameters in nanoseconds, together with the clock period in picoseconds. Each one is rounded up to whole clock cycles when the block is elaborated.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are high, `rvalid` is low, and `ready` is high whenever `deselect` is low.
- R2: A request is taken on a rising edge where `req` is high and `ready` is high. From that edge on, `mem_addr` carries the request address and `mem_ce_n` is low.
- R3: `mem_oe_n` goes low exactly (ACC − OE) cycles after `mem_ce_n` goes low and then stays low for exactly OE cycles. `mem_oe_n` is never low while `mem_ce_n` is high.
- R4: The byte on `mem_dq` is captured on the edge that ends the ACC-th cycle of chip select low. `rdata` then shows that byte together with `rvalid`, which is high for exactly one cycle and appears ACC+1 rising edges after the accepting edge, counting the accepting edge.
- R5: Both strobes rise on the capture edge, in the same cycle in which `rvalid` is first high.
- R6: `mem_addr` stays constant for as long as `mem_ce_n` is low. Changes on `req` or `addr` while a read is in flight are ignored.
- R7: `ready` stays low for DF cycles after `rvalid` and rises in the DF-th cycle. With `req` held high, `mem_ce_n` stays high for DF+1 cycles between two back-to-back reads.
- R8: While `deselect` is high, `ready` is low, requests are ignored, `mem_ce_n` stays high and no `rvalid` occurs.
- R9: ACC, OE and DF are each the matching nanosecond parameter rounded up at the clock period. At the defaults (4000 ps; 120, 60 and 50 ns) they are 30, 15 and 13 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, taken when `ready` is high |
| addr | input | 20 | Byte address of the request |
| deselect | input | 1 | Holds the device in standby and blocks requests |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | 8 | Captured byte |
| rvalid | output | 1 | One-cycle pulse marking `rdata` valid |
| mem_addr | output | 20 | Address bus to the EPROM |
| mem_ce_n | output | 1 | Active-low chip select to the EPROM |
| mem_oe_n | output | 1 | Active-low output gate to the EPROM |
| mem_dq | input | 8 | Data bus from the EPROM |

## Verification
The bench models the EPROM so that it returns the correct byte only after chip select, the output gate and the address have each been stable for their full windows. At every other time it returns the complement of the correct byte, so a capture even one cycle early produces a visibly wrong byte. Single reads are tried at all-zero, all-one, checkerboard and mixed addresses; this separates a correct address path from stuck or swapped bits and confirms the strobe offsets and durations. A back-to-back run with `req` held high measures the float gap and shows that a changed address is picked up only by the next read. A deselect run with requests pending shows that standby holds and that normal reads resume afterwards.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_FLOAT  = 2'd2
    } phase_e;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_strobe_seq.sv
module eprom_strobe_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int ACC_CYC = 30,
    parameter int OE_CYC  = 15,
    parameter int DF_CYC  = 13,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              deselect,
    output logic              ready,
    output logic              capture,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n
);

    localparam int OE_LEAD = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
    localparam logic [CNT_W-1:0] LEAD_V   = CNT_W'(OE_LEAD);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] DF_LAST  = CNT_W'((DF_CYC > 0) ? (DF_CYC - 1) : 0);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic                ce_n;
        logic                oe_n;
        logic [ADDR_W-1:0]   addr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic capture_d;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        seq_d     = seq_q;
        capture_d = 1'b0;
        cnt_inc   = seq_q.cnt + CNT_W'(1);
        case (seq_q.phase)
            PH_IDLE: begin
                if (req && !deselect) begin
                    seq_d.phase = PH_ACCESS;
                    seq_d.addr  = addr;
                    seq_d.cnt   = '0;
                    seq_d.ce_n  = 1'b0;
                    seq_d.oe_n  = (OE_LEAD == 0) ? 1'b0 : 1'b1;
                end
            end
            PH_ACCESS: begin
                seq_d.cnt = cnt_inc;
                if (cnt_inc == LEAD_V) begin
                    seq_d.oe_n = 1'b0;
                end
                if (seq_q.cnt == ACC_LAST) begin
                    capture_d   = 1'b1;
                    seq_d.ce_n  = 1'b1;
                    seq_d.oe_n  = 1'b1;
                    seq_d.cnt   = '0;
                    seq_d.phase = (DF_CYC == 0) ? PH_IDLE : PH_FLOAT;
                end
            end
            PH_FLOAT: begin
                seq_d.cnt = cnt_inc;
                if (seq_q.cnt == DF_LAST) begin
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_IDLE;
                end
            end
            default: begin
                seq_d.phase = PH_IDLE;
                seq_d.ce_n  = 1'b1;
                seq_d.oe_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.cnt   <= '0;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.addr  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready    = (seq_q.phase == PH_IDLE) && !deselect;
    assign capture  = capture_d;
    assign mem_addr = seq_q.addr;
    assign mem_ce_n = seq_q.ce_n;
    assign mem_oe_n = seq_q.oe_n;

    // R3
    strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_oe_n);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/eprom_capture.sv
module eprom_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d        = cap_q;
        cap_d.rvalid = capture;
        if (capture) begin
            cap_d.rdata = mem_dq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.rdata  <= '0;
            cap_q.rvalid <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata  = cap_q.rdata;
    assign rvalid = cap_q.rvalid;

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int CLK_PS = 4000,
    parameter int ACC_NS = 120,
    parameter int OE_NS  = 60,
    parameter int DF_NS  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              deselect,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);

    localparam int ACC_CYC = max_of(1, ns_to_cycles(ACC_NS, CLK_PS));
    localparam int OE_RAW  = max_of(1, ns_to_cycles(OE_NS, CLK_PS));
    localparam int OE_CYC  = (OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW;
    localparam int DF_CYC  = max_of(0, ns_to_cycles(DF_NS, CLK_PS));
    localparam int CNT_W   = $clog2(max_of(ACC_CYC, DF_CYC) + 2);
    localparam logic [CNT_W-1:0] DF_V = CNT_W'(DF_CYC);

    logic capture;

    eprom_strobe_seq #(
        .ADDR_W (ADDR_W),
        .ACC_CYC(ACC_CYC),
        .OE_CYC (OE_CYC),
        .DF_CYC (DF_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .addr    (addr),
        .deselect(deselect),
        .ready   (ready),
        .capture (capture),
        .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n)
    );

    eprom_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .mem_dq (mem_dq),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    // Checker-side count of cycles since chip select last went high.
    logic [CNT_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (!mem_ce_n) begin
            gap_d = '0;
        end else if (gap_q < DF_V) begin
            gap_d = gap_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= DF_V;
        end else begin
            gap_q <= gap_d;
        end
    end

    // R7
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (gap_q >= DF_V));

    // R8
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deselect && mem_ce_n) |=> mem_ce_n);

    // R8
    no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deselect |-> !ready);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (mem_ce_n && mem_oe_n && $past(!mem_oe_n)));

endmodule

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;

    localparam int T_ACC   = 30;
    localparam int T_OE    = 15;
    localparam int T_DF    = 13;
    localparam int OE_LEAD = T_ACC - T_OE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] addr = '0;
    logic        desel = 1'b0;
    logic        ready;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [19:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eprom_rd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .deselect(desel),
        .ready(ready), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    function automatic logic [7:0] rom_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    // EPROM model: correct byte only after every window is satisfied.
    int ce_run = 0, oe_run = 0, ad_run = 0;
    logic [19:0] ad_last = '0;
    always @(posedge clk) begin
        ce_run <= mem_ce_n ? 0 : ce_run + 1;
        oe_run <= mem_oe_n ? 0 : oe_run + 1;
        if (mem_addr != ad_last) begin
            ad_last <= mem_addr;
            ad_run  <= 1;
        end else begin
            ad_run <= ad_run + 1;
        end
    end
    assign mem_dq = (!mem_ce_n && !mem_oe_n && ce_run >= T_ACC-1 &&
                     oe_run >= T_OE-1 && ad_run >= T_ACC-1)
                    ? rom_byte(mem_addr) : ~rom_byte(mem_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R1 ce_n after reset", int'(mem_ce_n), 1);
        chk(mem_oe_n == 1'b1, "R1 oe_n after reset", int'(mem_oe_n), 1);
        chk(rvalid == 1'b0, "R1 rvalid after reset", int'(rvalid), 0);
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    endtask

    // Single read: R2 R3 R4 R5 R6 R7 R9
    task automatic t_read(input logic [19:0] a);
        int n = 0, ce_cnt = 0, oe_cnt = 0, first_oe = -1, bad_addr = 0, m = 0;
        bit early_ready = 1'b0;
        wait_ready();
        req = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        addr = ~a;
        n = 1;
        chk(mem_ce_n == 1'b0, "R2 ce_n low after accept", int'(mem_ce_n), 0);
        chk(mem_addr == a, "R2 address driven", int'(mem_addr), int'(a));
        forever begin
            if (!mem_ce_n) begin
                ce_cnt++;
                if (mem_addr != a) bad_addr++;
            end
            if (!mem_oe_n) begin
                if (first_oe < 0) first_oe = n;
                oe_cnt++;
            end
            if (rvalid || n > T_ACC + 5) break;
            @(negedge clk);
            n++;
        end
        chk(first_oe == OE_LEAD + 1, "R3 oe_n fall offset", first_oe, OE_LEAD + 1);
        chk(oe_cnt == T_OE, "R3 oe_n low cycles", oe_cnt, T_OE);
        chk(n == T_ACC + 1, "R4 R9 read latency", n, T_ACC + 1);
        chk(rdata == rom_byte(a), "R4 rdata", int'(rdata), int'(rom_byte(a)));
        chk(mem_ce_n && mem_oe_n, "R5 strobes released with rvalid",
            int'({mem_ce_n, mem_oe_n}), 3);
        chk(ce_cnt == T_ACC && bad_addr == 0, "R6 address held during ce_n low",
            bad_addr, 0);
        forever begin
            @(negedge clk);
            m++;
            if (m == 1) chk(!rvalid, "R4 rvalid single pulse", int'(rvalid), 0);
            if (ready || m > T_DF + 5) break;
            if (!mem_ce_n) early_ready = 1'b1;
        end
        chk(m == T_DF && !early_ready, "R7 R9 ready after float time", m, T_DF);
    endtask

    // Back-to-back with req held: R6 R7
    task automatic t_back2back(input logic [19:0] a, input logic [19:0] b);
        int g = 0, guard = 0;
        wait_ready();
        req = 1'b1;
        addr = a;
        @(negedge clk);
        addr = b;
        while (!rvalid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(rdata == rom_byte(a), "R6 first read ignores in-flight address change",
            int'(rdata), int'(rom_byte(a)));
        while (mem_ce_n && g < 100) begin
            g++;
            @(negedge clk);
        end
        chk(g == T_DF + 1, "R7 ce_n high gap between reads", g, T_DF + 1);
        req = 1'b0;
        guard = 0;
        while (!rvalid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(rdata == rom_byte(b), "R7 second read data", int'(rdata), int'(rom_byte(b)));
        wait_ready();
    endtask

    // R8
    task automatic t_deselect();
        int ce_low = 0, rv = 0, rdy = 0;
        @(negedge clk);
        desel = 1'b1;
        req = 1'b1;
        addr = 20'h12345;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!mem_ce_n) ce_low++;
            if (rvalid) rv++;
            if (ready) rdy++;
        end
        chk(ce_low == 0, "R8 ce_n held high in standby", ce_low, 0);
        chk(rv == 0, "R8 no rvalid in standby", rv, 0);
        chk(rdy == 0, "R8 ready low in standby", rdy, 0);
        req = 1'b0;
        desel = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R8 ready back after deselect drops", int'(ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read(20'h00000);
        t_read(20'hFFFFF);
        t_read(20'hAAAAA);
        t_read(20'h5A5A5);
        t_back2back(20'h13579, 20'hEDCBA);
        t_deselect();
        t_read(20'h0F0F1);
        finish_run();
    end

endmodule